// File: doc/BRIEF.md
# Two-Level Page Translator with TLB

This block turns a 32-bit linear address into a 32-bit physical address using 4 KiB pages. Translation uses a page directory and page tables. A caller presents one request at a time with a valid/ready handshake. If paging is switched off, the address is returned unchanged. If paging is on, a fully associative translation cache is checked first. A hit returns the result in the cycle after acceptance.

On a cache miss, the walker reads two entries through a single memory read port: first the directory entry, then the table entry. Both must have their present bit set. The walker then loads the translation into the cache and returns the physical address. If either entry is absent, the walker reports a page fault instead. A flush input clears the whole cache. The surrounding logic pulses it whenever the directory base changes or the page tables are edited.

Top module: `pt_translator`

## Requirements
- R1: When `paging_en` is 0 at acceptance, `resp_phys` equals the accepted linear address one cycle after acceptance, `resp_fault` is 0 and no memory read is issued.
- R2: The directory entry is read at byte address {dir_base[31:12], lin[31:22], 2'b00}, so linear bits 31:22 select one of 1024 four-byte directory entries.
- R3: The table entry is read at {pde[31:12], lin[21:12], 2'b00}. The result is {pte[31:12], lin[11:0]}. With table entry 0 holding 00100000h (present), linear 00000000h–00000FFFh maps to 00100000h–00100FFFh.
- R4: Only bit 0 (present) and bits 31:12 (frame) of an entry are used. Bits 11:1 (dirty, referenced and protection bits) have no effect on the result.
- R5: A directory entry with bit 0 clear causes a fault after exactly one memory read. On a fault, `resp_phys` carries the faulting linear address.
- R6: A table entry with bit 0 clear causes a fault after exactly two memory reads.
- R7: A miss with both levels present costs exactly two reads. A later access to the same page hits the cache, issues no read, and responds one cycle after acceptance.
- R8: The cache holds `TLB_DEPTH` translations and replaces them round-robin: after `TLB_DEPTH`+1 distinct pages, the first page loaded misses again while the others still hit.
- R9: A one-cycle `flush` pulse invalidates every cached translation, so the next access walks the tables again and sees their current contents.
- R10: `req_ready` is high only while idle, so it is low during a walk. `resp_valid` is a one-cycle pulse per accepted request.
- R11: Faults are never cached: repeating a faulting access walks again and faults again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_lin | input | 32 | Linear address to translate |
| paging_en | input | 1 | 1 = translate, 0 = pass the address through |
| dir_base | input | 32 | Page directory address; bits 11:0 are ignored |
| flush | input | 1 | Invalidate all cache entries |
| mem_req | output | 1 | One-cycle pulse starting a memory read |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry read from memory |
| resp_valid | output | 1 | Result valid (one cycle) |
| resp_phys | output | 32 | Physical address, or the linear address on a fault |
| resp_fault | output | 1 | Page fault at either level |

## Verification
The in-line assertions check these properties on every cycle:
- the pass-through result when paging is off;
- that a cache hit completes without a memory read;
- that a response is a single-cycle pulse followed by readiness;
- that an absent directory entry leads straight to a fault;
- that the table read address follows the directory data;
- that cache hits stay one-hot;
- that a flush leaves no valid entry.

Some behaviours depend on table contents chosen over many requests, so only the bench's scenarios can show them. These are:
- round-robin eviction order;
- that stale translations persist until a flush and vanish after one;
- that faults are refetched;
- that dirty, referenced and protection bits are ignored.

// File: rtl/pt_pkg.sv
package pt_pkg;
    localparam int ADDR_W  = 32;
    localparam int OFF_W   = 12;
    localparam int IDX_W   = 10;
    localparam int VPN_W   = ADDR_W - OFF_W;
    localparam int FRAME_W = ADDR_W - OFF_W;
    localparam int PRESENT = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_DIR,
        ST_READ_TABLE,
        ST_DONE,
        ST_FAULT
    } walk_state_t;

    typedef struct packed {
        logic               valid;
        logic [VPN_W-1:0]   vpn;
        logic [FRAME_W-1:0] frame;
    } tlb_entry_t;

    function automatic logic [ADDR_W-1:0] dir_entry_addr(
        input logic [ADDR_W-1:0] base, input logic [ADDR_W-1:0] lin);
        return {base[ADDR_W-1:OFF_W], lin[ADDR_W-1:ADDR_W-IDX_W], 2'b00};
    endfunction

    function automatic logic [ADDR_W-1:0] tbl_entry_addr(
        input logic [ADDR_W-1:0] pde, input logic [ADDR_W-1:0] lin);
        return {pde[ADDR_W-1:OFF_W], lin[OFF_W+IDX_W-1:OFF_W], 2'b00};
    endfunction

    function automatic logic [ADDR_W-1:0] join_phys(
        input logic [FRAME_W-1:0] frame, input logic [ADDR_W-1:0] lin);
        return {frame, lin[OFF_W-1:0]};
    endfunction
endpackage

// File: rtl/pt_tlb.sv
module pt_tlb
    import pt_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic [VPN_W-1:0]   look_vpn,
    output logic               look_hit,
    output logic [FRAME_W-1:0] look_frame,
    input  logic               fill_en,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [FRAME_W-1:0] fill_frame
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    tlb_entry_t         ent [DEPTH];
    logic [DEPTH-1:0]   hit_vec;
    logic [DEPTH-1:0]   valid_vec;
    logic [PTR_W-1:0]   victim;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g]   = ent[g].valid && (ent[g].vpn == look_vpn);
        assign valid_vec[g] = ent[g].valid;
    end

    always_comb begin
        look_frame = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i]) look_frame = look_frame | ent[i].frame;
        end
    end
    assign look_hit = |hit_vec;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
            if (rst) victim <= '0;
        end else if (fill_en) begin
            ent[victim] <= '{valid: 1'b1, vpn: fill_vpn, frame: fill_frame};
            victim      <= (victim == PTR_W'(DEPTH - 1)) ? '0 : victim + 1'b1;
        end
    end

    // R8: a page is never held twice, so at most one entry matches
    p_hit_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R9: after a flush no entry is valid
    p_flush_clears_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_lin,
    input  logic               paging_en,
    input  logic [ADDR_W-1:0]  dir_base,
    input  logic               look_hit,
    input  logic [FRAME_W-1:0] look_frame,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_rvalid,
    input  logic [ADDR_W-1:0]  mem_rdata,
    output logic               fill_en,
    output logic [VPN_W-1:0]   fill_vpn,
    output logic [FRAME_W-1:0] fill_frame,
    output logic               resp_valid,
    output logic [ADDR_W-1:0]  resp_phys,
    output logic               resp_fault
);
    walk_state_t       state;
    logic [ADDR_W-1:0] lin_q;
    logic [ADDR_W-1:0] phys_q;

    assign req_ready  = (state == ST_IDLE);
    assign resp_valid = (state == ST_DONE) || (state == ST_FAULT);
    assign resp_fault = (state == ST_FAULT);
    assign resp_phys  = phys_q;

    assign fill_en    = (state == ST_READ_TABLE) && mem_rvalid && mem_rdata[PRESENT];
    assign fill_vpn   = lin_q[ADDR_W-1:OFF_W];
    assign fill_frame = mem_rdata[ADDR_W-1:OFF_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            lin_q    <= '0;
            phys_q   <= '0;
            mem_req  <= 1'b0;
            mem_addr <= '0;
        end else begin
            mem_req <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    lin_q <= req_lin;
                    if (!paging_en) begin
                        phys_q <= req_lin;
                        state  <= ST_DONE;
                    end else if (look_hit) begin
                        phys_q <= join_phys(look_frame, req_lin);
                        state  <= ST_DONE;
                    end else begin
                        mem_req  <= 1'b1;
                        mem_addr <= dir_entry_addr(dir_base, req_lin);
                        state    <= ST_READ_DIR;
                    end
                end
                ST_READ_DIR: if (mem_rvalid) begin
                    if (!mem_rdata[PRESENT]) begin
                        phys_q <= lin_q;
                        state  <= ST_FAULT;
                    end else begin
                        mem_req  <= 1'b1;
                        mem_addr <= tbl_entry_addr(mem_rdata, lin_q);
                        state    <= ST_READ_TABLE;
                    end
                end
                ST_READ_TABLE: if (mem_rvalid) begin
                    if (!mem_rdata[PRESENT]) begin
                        phys_q <= lin_q;
                        state  <= ST_FAULT;
                    end else begin
                        phys_q <= join_phys(mem_rdata[ADDR_W-1:OFF_W], lin_q);
                        state  <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: paging off returns the address unchanged one cycle later
    p_bypass_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !paging_en) |=>
        (resp_valid && !resp_fault && resp_phys == $past(req_lin)));

    // R7: a cache hit completes without touching memory
    p_hit_no_read_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && paging_en && look_hit) |=>
        (resp_valid && !mem_req));

    // R3: the table read address is derived from the directory data
    p_table_addr_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READ_DIR && mem_rvalid && mem_rdata[PRESENT]) |=>
        (mem_req && mem_addr[ADDR_W-1:OFF_W] == $past(mem_rdata[ADDR_W-1:OFF_W])));

    // R5: an absent directory entry goes straight to a fault
    p_dir_fault_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READ_DIR && mem_rvalid && !mem_rdata[PRESENT]) |=>
        (resp_valid && resp_fault && !mem_req));

    // R10: a response lasts one cycle and is followed by readiness
    p_resp_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> (!resp_valid && req_ready));
endmodule

// File: rtl/pt_translator.sv
module pt_translator
    import pt_pkg::*;
#(
    parameter int TLB_DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_lin,
    input  logic        paging_en,
    input  logic [31:0] dir_base,
    input  logic        flush,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        resp_valid,
    output logic [31:0] resp_phys,
    output logic        resp_fault
);
    logic               look_hit;
    logic [FRAME_W-1:0] look_frame;
    logic               fill_en;
    logic [VPN_W-1:0]   fill_vpn;
    logic [FRAME_W-1:0] fill_frame;

    pt_tlb #(.DEPTH(TLB_DEPTH)) u_tlb (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .look_vpn   (req_lin[ADDR_W-1:OFF_W]),
        .look_hit   (look_hit),
        .look_frame (look_frame),
        .fill_en    (fill_en),
        .fill_vpn   (fill_vpn),
        .fill_frame (fill_frame)
    );

    pt_walker u_walk (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_lin    (req_lin),
        .paging_en  (paging_en),
        .dir_base   (dir_base),
        .look_hit   (look_hit),
        .look_frame (look_frame),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .fill_en    (fill_en),
        .fill_vpn   (fill_vpn),
        .fill_frame (fill_frame),
        .resp_valid (resp_valid),
        .resp_phys  (resp_phys),
        .resp_fault (resp_fault)
    );
endmodule

// File: tb/pt_translator_bench.sv
module pt_translator_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin = '0;
    logic        paging_en = 1'b0;
    logic [31:0] dir_base = 32'h0000_1000;
    logic        flush = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        resp_valid;
    logic [31:0] resp_phys;
    logic        resp_fault;

    int checks = 0;
    int failures = 0;
    int rd_cnt = 0;
    int cyc = 0;
    bit finished = 0;
    logic [31:0] mem [4096];
    logic        p1 = 1'b0;
    logic [11:0] a1 = '0;
    logic [31:0] last_addr = '0;
    logic [31:0] prev_addr = '0;
    logic        mid_ready;
    logic        pulse_after;

    always #4 clk = ~clk;

    pt_translator u_pt_translator (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_lin(req_lin), .paging_en(paging_en), .dir_base(dir_base),
        .flush(flush), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .resp_valid(resp_valid), .resp_phys(resp_phys), .resp_fault(resp_fault)
    );

    // memory model: fixed two-cycle read latency
    always @(posedge clk) begin
        p1         <= mem_req;
        a1         <= mem_addr[13:2];
        mem_rvalid <= p1;
        mem_rdata  <= mem[a1];
        if (mem_req) begin
            rd_cnt    <= rd_cnt + 1;
            prev_addr <= last_addr;
            last_addr <= mem_addr;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000 && !finished) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual=%0d expected=<50000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xlate(input logic [31:0] lin, input bit pe,
                         output logic [31:0] ph, output bit flt, output int rd, output int lat);
        int r0;
        @(negedge clk);
        req_lin = lin; paging_en = pe; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        r0 = rd_cnt;
        @(negedge clk);
        req_valid = 1'b0;
        mid_ready = req_ready;
        lat = 1;
        while (!resp_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        ph = resp_phys; flt = resp_fault;
        @(negedge clk);
        pulse_after = resp_valid;
        rd = rd_cnt - r0;
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R10 reset ready", {31'b0, req_ready}, 32'h1);
        chk(resp_valid == 1'b0, "R10 reset resp_valid", {31'b0, resp_valid}, 32'h0);
        chk(mem_req == 1'b0, "R10 reset mem_req", {31'b0, mem_req}, 32'h0);
    endtask

    task automatic t_bypass();
        logic [31:0] ph; bit f; int rd, lat;
        xlate(32'hDEAD_BEEF, 1'b0, ph, f, rd, lat);
        chk(ph == 32'hDEAD_BEEF && !f, "R1 bypass phys", ph, 32'hDEAD_BEEF);
        chk(rd == 0 && lat == 1, "R1 bypass reads/latency", rd * 256 + lat, 32'h1);
    endtask

    task automatic t_first_walk();
        logic [31:0] ph; bit f; int rd, lat;
        xlate(32'h0000_0ABC, 1'b1, ph, f, rd, lat);
        chk(ph == 32'h0010_0ABC && !f, "R3 example map", ph, 32'h0010_0ABC);
        chk(rd == 2, "R7 miss reads", rd, 2);
        chk(mid_ready == 1'b0, "R10 ready low during walk", {31'b0, mid_ready}, 32'h0);
        chk(pulse_after == 1'b0, "R10 resp one cycle", {31'b0, pulse_after}, 32'h0);
        xlate(32'h0000_0FFF, 1'b1, ph, f, rd, lat);
        chk(ph == 32'h0010_0FFF && !f, "R3 page end", ph, 32'h0010_0FFF);
        chk(rd == 0 && lat == 1, "R7 hit reads/latency", rd * 256 + lat, 32'h1);
    endtask

    task automatic t_second_dir();
        logic [31:0] ph; bit f; int rd, lat;
        xlate(32'h0040_3ABC, 1'b1, ph, f, rd, lat);
        chk(prev_addr == 32'h0000_1004, "R2 dir entry address", prev_addr, 32'h0000_1004);
        chk(last_addr == 32'h0000_300C, "R3 table entry address", last_addr, 32'h0000_300C);
        chk(ph == 32'h1234_5ABC && !f, "R3 second table", ph, 32'h1234_5ABC);
    endtask

    task automatic t_ignored_bits();
        logic [31:0] ph; bit f; int rd, lat;
        xlate(32'h0000_1123, 1'b1, ph, f, rd, lat);
        chk(ph == 32'h00AB_C123 && !f, "R4 flag bits ignored", ph, 32'h00AB_C123);
    endtask

    task automatic t_faults();
        logic [31:0] ph; bit f; int rd, lat;
        xlate(32'h0080_0456, 1'b1, ph, f, rd, lat);
        chk(f == 1'b1 && rd == 1, "R5 dir fault, one read", {f, 23'b0, 8'(rd)}, 32'h8000_0001);
        chk(ph == 32'h0080_0456, "R5 fault address", ph, 32'h0080_0456);
        xlate(32'h0000_5010, 1'b1, ph, f, rd, lat);
        chk(f == 1'b1 && rd == 2, "R6 table fault, two reads", {f, 23'b0, 8'(rd)}, 32'h8000_0002);
        xlate(32'h0000_5010, 1'b1, ph, f, rd, lat);
        chk(f == 1'b1 && rd == 2, "R11 fault not cached", {f, 23'b0, 8'(rd)}, 32'h8000_0002);
    endtask

    task automatic t_flush();
        logic [31:0] ph; bit f; int rd, lat;
        mem[12'h800] = 32'h0020_0001;
        xlate(32'h0000_0020, 1'b1, ph, f, rd, lat);
        chk(ph == 32'h0010_0020 && rd == 0, "R9 stale before flush", ph, 32'h0010_0020);
        do_flush();
        xlate(32'h0000_0010, 1'b1, ph, f, rd, lat);
        chk(ph == 32'h0020_0010 && rd == 2, "R9 refetch after flush", ph, 32'h0020_0010);
    endtask

    task automatic t_round_robin();
        logic [31:0] ph; bit f; int rd, lat;
        int bad = 0;
        do_flush();
        for (int i = 8; i < 40; i++) begin
            xlate(32'(i) << 12, 1'b1, ph, f, rd, lat);
            if (rd != 2 || ph != (32'(32'h500 + i) << 12)) bad++;
        end
        chk(bad == 0, "R8 fill 32 pages", bad, 0);
        xlate(32'h0000_8000, 1'b1, ph, f, rd, lat);
        chk(rd == 0, "R8 full TLB still hits", rd, 0);
        xlate(32'h0002_8000, 1'b1, ph, f, rd, lat);
        chk(rd == 2 && ph == 32'h0052_8000, "R8 33rd page walks", ph, 32'h0052_8000);
        xlate(32'h0000_8000, 1'b1, ph, f, rd, lat);
        chk(rd == 2, "R8 oldest evicted", rd, 2);
        xlate(32'h0000_A000, 1'b1, ph, f, rd, lat);
        chk(rd == 0 && ph == 32'h0050_A000, "R8 other page kept", rd, 0);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        mem[12'h400] = 32'h0000_2061;            // dir 0 -> table at 2000h
        mem[12'h401] = 32'h0000_3001;            // dir 1 -> table at 3000h
        mem[12'h800] = 32'h0010_0061;            // table0[0]
        mem[12'h801] = 32'h00AB_CFFF;            // table0[1], all flag bits set
        mem[12'h805] = 32'h00AB_D000;            // table0[5] absent
        for (int i = 8; i <= 40; i++) mem[12'h800 + i] = ((32'h500 + i) << 12) | 32'h1;
        mem[12'hC03] = 32'h1234_5001;            // table1[3]
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_first_walk();
        t_second_dir();
        t_ignored_bits();
        t_faults();
        t_flush();
        t_round_robin();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule